// File: doc/BRIEF.md
# SHA-1 Message Schedule Window

This block supplies the compression rounds of a SHA-1 engine with the message schedule word for the current round, one word per round and eighty words per block. It keeps only a sixteen-word window of 32-bit registers, not the whole expanded schedule. A start strobe fills the window from a 512-bit block. Each advance strobe drops the oldest word and appends a newly expanded word. The word for the current round is always the oldest word in the window, so it is valid combinationally from register outputs in the cycle the round logic uses it.

The engine raises `init_i` for one cycle when a block starts. It then raises `next_i` once per round, and may pause between rounds. After the last round the window holds its value until the next start.

Top module: `msg_sched_win`

## Requirements
- R1: An active-low asynchronous reset clears the window and the round index at once, without a clock edge; `w_o` reads 0 while reset is held.
- R2: In the cycle after `init_i` is sampled high, `w_o` equals the most significant 32 bits of `block_i` (bits 511:480), and the round index is 0.
- R3: For rounds 0 to 15, `w_o` equals block word t, taken as `block_i[511-32*t -: 32]` (word 0 is the most significant).
- R4: For rounds 16 to 79, `w_o` equals the left rotation by one bit of the XOR of the words from rounds t-3, t-8, t-14 and t-16.
- R5: Each cycle in which `next_i` is high and `init_i` is low advances the schedule by exactly one round. A cycle with both strobes low leaves `w_o` unchanged.
- R6: When `init_i` and `next_i` are high in the same cycle, the load wins: the next cycle shows word 0 of the new block.
- R7: Once round 79 is reached, further `next_i` pulses have no effect. `w_o` keeps showing word 79 until the next `init_i`.
- R8: An `init_i` in the middle of a block discards the current window and restarts at round 0 with the block now on `block_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| block_i | input | 512 | Message block, word 0 in the top bits |
| init_i | input | 1 | Load the window from `block_i`, restart at round 0 |
| next_i | input | 1 | Advance one round |
| w_o | output | 32 | Schedule word for the current round |

## Verification
A corrupted window slot stays hidden until it reaches the oldest position. A slot that is wrong at position k shows on `w_o` after k advances. Through the expansion taps, it also corrupts every later word that reads it, so one fault spreads across the rest of the block. The bench therefore compares `w_o` in every cycle of full 80-round runs, with and without stalls. A wrong word at any tap position then shows within sixteen rounds. A round index that is off by one shows at the end of a block, because the hold at round 79 then comes one pulse early or late.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  // distances back from the word being produced
  localparam int unsigned LAG_A = 3;
  localparam int unsigned LAG_B = 8;
  localparam int unsigned LAG_C = 14;
  localparam int unsigned LAG_D = 16;

  function automatic logic [31:0] rotl1(input logic [31:0] x);
    return {x[30:0], x[31]};
  endfunction
endpackage

// File: rtl/msw_window.sv
module msw_window #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned BLK_W = WORD_W * DEPTH
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic                           shift_i,
  input  logic [BLK_W-1:0]               block_i,
  input  logic [WORD_W-1:0]              new_word_i,
  output logic [DEPTH-1:0][WORD_W-1:0]   win_o
);
  logic [DEPTH-1:0][WORD_W-1:0] win_q;

  // slot 0 is the oldest word, slot DEPTH-1 the newest
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WORD_W-1:0] shift_src;
    if (i == DEPTH - 1) begin : g_tail
      assign shift_src = new_word_i;
    end else begin : g_body
      assign shift_src = win_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[i] <= '0;
      end else if (load_i) begin
        win_q[i] <= block_i[BLK_W-1-i*WORD_W -: WORD_W];
      end else if (shift_i) begin
        win_q[i] <= shift_src;
      end
    end
  end

  assign win_o = win_q;
endmodule

// File: rtl/msw_expand.sv
module msw_expand #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] win_i,
  output logic [WORD_W-1:0]            new_word_o
);
  import msg_sched_pkg::*;

  // window holds W[t..t+DEPTH-1]; produce W[t+DEPTH]
  localparam int unsigned IDX_A = DEPTH - LAG_A;
  localparam int unsigned IDX_B = DEPTH - LAG_B;
  localparam int unsigned IDX_C = DEPTH - LAG_C;
  localparam int unsigned IDX_D = DEPTH - LAG_D;

  logic [WORD_W-1:0] mix;

  always_comb begin
    mix        = win_i[IDX_A] ^ win_i[IDX_B] ^ win_i[IDX_C] ^ win_i[IDX_D];
    new_word_o = rotl1(mix);
  end
endmodule

// File: rtl/msw_round_ctr.sv
module msw_round_ctr #(
  parameter int unsigned ROUNDS = 80,
  localparam int unsigned RND_W = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [RND_W-1:0] round_o,
  output logic             can_adv_o
);
  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  logic [RND_W-1:0] round_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      round_q <= '0;
    end else if (clear_i) begin
      round_q <= '0;
    end else if (adv_i && round_q != LAST) begin
      round_q <= round_q + RND_W'(1);
    end
  end

  assign round_o   = round_q;
  assign can_adv_o = (round_q != LAST);
endmodule

// File: rtl/msg_sched_win.sv
module msg_sched_win #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ROUNDS = 80,
  localparam int unsigned BLK_W = WORD_W * DEPTH,
  localparam int unsigned RND_W = $clog2(ROUNDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  block_i,
  input  logic              init_i,
  input  logic              next_i,
  output logic [WORD_W-1:0] w_o
);
  logic [DEPTH-1:0][WORD_W-1:0] win;
  logic [WORD_W-1:0]            new_word;
  logic [RND_W-1:0]             round_q;
  logic                         can_adv;
  logic                         shift;

  // load has priority; no shifting past the last round
  assign shift = next_i & ~init_i & can_adv;

  msw_round_ctr #(.ROUNDS(ROUNDS)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (init_i),
    .adv_i     (shift),
    .round_o   (round_q),
    .can_adv_o (can_adv)
  );

  msw_expand #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_expand (
    .win_i      (win),
    .new_word_o (new_word)
  );

  msw_window #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_i),
    .shift_i    (shift),
    .block_i    (block_i),
    .new_word_i (new_word),
    .win_o      (win)
  );

  assign w_o = win[0];
endmodule

// File: rtl/msg_sched_win_chk.sv
module msg_sched_win_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ROUNDS = 80,
  localparam int unsigned BLK_W = WORD_W * DEPTH,
  localparam int unsigned RND_W = $clog2(ROUNDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BLK_W-1:0]  block_i,
  input logic              init_i,
  input logic              next_i,
  input logic [WORD_W-1:0] w_o,
  input logic [RND_W-1:0]  round_q,
  input logic              can_adv
);
  p_load_word0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (w_o == $past(block_i[BLK_W-1 -: WORD_W])) && (round_q == '0));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !next_i) |=> $stable(w_o) && $stable(round_q));

  p_round_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !init_i && can_adv) |=> round_q == $past(round_q) + RND_W'(1));

  p_init_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && next_i) |=> round_q == '0);

  p_end_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !init_i && !can_adv) |=> $stable(w_o) && $stable(round_q));

  p_round_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_q <= RND_W'(ROUNDS - 1));
endmodule

bind msg_sched_win msg_sched_win_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .ROUNDS(ROUNDS)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .block_i (block_i),
  .init_i  (init_i),
  .next_i  (next_i),
  .w_o     (w_o),
  .round_q (round_q),
  .can_adv (can_adv)
);

// File: tb/test_msg_sched_win.sv
module test_msg_sched_win;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [511:0] block_i;
  logic         init_i;
  logic         next_i;
  logic [31:0]  w_o;

  always #4 clk_i = ~clk_i;

  msg_sched_win i_msg_sched_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .block_i (block_i),
    .init_i  (init_i),
    .next_i  (next_i),
    .w_o     (w_o)
  );

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  logic [31:0] sched[80];
  int          idx    = 0;
  bit          done   = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // full 80-word expansion, independent of any window
  task automatic build_sched(input logic [511:0] blk);
    for (int t = 0; t < 16; t++) sched[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 80; t++) begin
      logic [31:0] x;
      x = sched[t-3] ^ sched[t-8] ^ sched[t-14] ^ sched[t-16];
      sched[t] = {x[30:0], x[31]};
    end
  endtask

  function automatic string tag_of(input int i);
    return (i < 16) ? "R3" : "R4";
  endfunction

  // driver: one cycle of stimulus plus its expected result
  task automatic step(input bit ini, input bit nxt, input string req);
    @(negedge clk_i);
    init_i = ini;
    next_i = nxt;
    if (ini) begin
      build_sched(block_i);
      idx = 0;
    end else if (nxt && idx < 79) begin
      idx++;
    end
    sb_q.push_back('{exp: sched[idx], req: req});
  endtask

  task automatic run_rounds(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1, tag_of(idx + 1 > 79 ? 79 : idx + 1));
  endtask

  task automatic drain;
    @(negedge clk_i);
    init_i = 1'b0;
    next_i = 1'b0;
    while (sb_q.size() != 0) @(negedge clk_i);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(w_o, it.exp, it.req);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni  = 1'b0;
    init_i  = 1'b0;
    next_i  = 1'b0;
    block_i = '0;
    repeat (3) @(negedge clk_i);
    check(w_o, 32'h0, "R1 reset state");
    rst_ni = 1'b1;

    // incrementing words, full run, then extra advances past the end
    for (int i = 0; i < 16; i++) block_i[511-32*i -: 32] = 32'h0101_0101 * (i + 1);
    step(1'b1, 1'b0, "R2");
    run_rounds(79);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");

    // stalls between advances
    for (int i = 0; i < 16; i++) block_i[511-32*i -: 32] = 32'hA5C3_0F96 ^ (32'h1357_9BDF << i);
    step(1'b1, 1'b0, "R2");
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b0, "R5");
      step(1'b0, 1'b1, tag_of(idx + 1));
    end

    // simultaneous strobes: load wins
    for (int i = 0; i < 16; i++) block_i[511-32*i -: 32] = 32'hDEAD_0000 + i * 32'h0011_2233;
    step(1'b1, 1'b1, "R6");
    run_rounds(25);

    // restart mid-block with a different block
    block_i = {16{32'hFFFF_FFFF}};
    step(1'b1, 1'b0, "R8");
    run_rounds(79);
    step(1'b0, 1'b1, "R7");
    drain();

    // asynchronous reset between edges
    #1;
    rst_ni = 1'b0;
    #1;
    check(w_o, 32'h0, "R1 async clear");
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) block_i[511-32*i -: 32] = 32'h8000_0001 >> i;
    step(1'b1, 1'b0, "R2");
    run_rounds(30);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule